// File: doc/BRIEF.md
# Dual-Depth UART FIFO Controller

This block holds the receive and transmit byte queues of a 16550-style UART together with their control and status logic. Software configures it through one write-only control byte (queue enable, per-queue clear strobes, a deep-queue select and a two-bit receive threshold code). It reads one status byte back that carries the pending-interrupt identity and the active queue mode. The serializers on either side move bytes through simple push/pop strobes and see the fill counts.

With the queues disabled each direction holds a single byte. With the queues enabled each direction is either a 16-entry queue or, when the deep-queue bit is also set, a 64-entry queue. The threshold code maps to a different set of receive levels in each depth. The receive-data interrupt stays raised while the receive fill count is at or above the selected level. Any change of the enable or deep-queue bit empties both queues, so no data survives a depth change.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the queues are disabled, both counts are 0, `rx_irq_o` and `rx_overrun_o` are 0, and `iir_o` reads 8'h01.
- R2: Control bit 0 enables the queues. While enabled, `iir_o[7:6]` reads 2'b11. While disabled, `iir_o[7:5]` reads 3'b000 and each direction holds one byte.
- R3: Control bit 5 selects 64-entry mode only while bit 0 is also 1. In that case `iir_o[7:5]` reads 3'b111. With bit 0 at 0, bit 5 has no effect on depth and `iir_o[7:5]` reads 3'b000.
- R4: In 16-entry mode each queue accepts at most 16 bytes.
- R5: In 64-entry mode each queue accepts at most 64 bytes.
- R6: In 16-entry mode, control bits 7:6 select receive levels 00=1, 01=4, 10=8, 11=14. With the queues disabled the level is 1.
- R7: In 64-entry mode, control bits 7:6 select receive levels 00=1, 01=16, 10=32, 11=56.
- R8: `rx_irq_o` is 1 exactly while `rx_count_o` is at or above the selected level. It falls once pops bring the count below that level.
- R9: `iir_o[3:0]` reads 4'b0100 while `rx_irq_o` is 1 and 4'b0001 otherwise, and `iir_o[4]` reads 0.
- R10: A control write with bit 1 set empties the receive queue and clears the overrun flag. A write with bit 2 set empties the transmit queue. Neither bit is stored, so a later write without them leaves the counts unchanged.
- R11: A control write that changes bit 0 or bit 5 from its stored value empties both queues.
- R12: A receive push into a full queue (with no pop in the same cycle) is dropped and sets `rx_overrun_o`. The flag stays set until a receive clear (R10 or R11).
- R13: Bytes leave each queue in push order. The popped byte appears on the data output in the cycle after the pop. A pop from an empty queue leaves the data output and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcr_wr_i | input | 1 | Control byte write strobe |
| fcr_wdata_i | input | 8 | Control byte write data |
| iir_o | output | 8 | Interrupt identity and mode status byte |
| rx_push_i | input | 1 | Push a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_pop_i | input | 1 | Pop the oldest received byte |
| rx_data_o | output | 8 | Last popped received byte |
| rx_count_o | output | 7 | Receive fill count |
| rx_overrun_o | output | 1 | Sticky receive overrun flag |
| rx_irq_o | output | 1 | Receive-data-available interrupt |
| tx_push_i | input | 1 | Push a byte to transmit |
| tx_data_i | input | 8 | Byte to transmit |
| tx_pop_i | input | 1 | Pop the oldest byte to transmit |
| tx_data_o | output | 8 | Last popped transmit byte |
| tx_count_o | output | 7 | Transmit fill count |

## Verification
Each of the eight threshold codes is driven to one byte below its level and then one byte to the level. A design with a swapped or shifted level table raises the interrupt one level early or late. The bench fills both depths past capacity and then drains them. A design with the wrong wrap point or a missing drop shows a count above 16 or 64, lost ordering or no overrun. It also sets the deep-queue bit with the queues disabled, sends clear strobes alone and then repeats writes without them, and toggles bits 0 and 5 while both queues hold data. These catch a design that stores the strobes, honours the deep bit while disabled, or carries stale bytes across a depth change. A final pop from an empty queue exposes a design that moves its read pointer or corrupts the data output.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned STD_DEPTH = 16;
  localparam int unsigned EXT_DEPTH = 64;
  localparam int unsigned CNT_W     = $clog2(EXT_DEPTH + 1);

  typedef struct packed {
    logic       en;
    logic       ext;
    logic [1:0] trig;
  } fcr_cfg_t;
endpackage

// File: rtl/ufc_fcr_regs.sv
module ufc_fcr_regs
  import uart_fifo_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  logic     en_bit_i,
  input  logic     rx_clr_bit_i,
  input  logic     tx_clr_bit_i,
  input  logic     ext_bit_i,
  input  logic [1:0] trig_i,
  output fcr_cfg_t cfg_o,
  output logic     rx_clr_o,
  output logic     tx_clr_o
);
  fcr_cfg_t cfg_q;
  logic     mode_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      cfg_q.en   <= en_bit_i;
      cfg_q.ext  <= ext_bit_i;
      cfg_q.trig <= trig_i;
    end
  end

  // depth change flushes both directions; clear strobes are never stored
  assign mode_chg = wr_i & ((en_bit_i ^ cfg_q.en) | (ext_bit_i ^ cfg_q.ext));
  assign rx_clr_o = (wr_i & rx_clr_bit_i) | mode_chg;
  assign tx_clr_o = (wr_i & tx_clr_bit_i) | mode_chg;
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/ufc_mode_map.sv
module ufc_mode_map
  import uart_fifo_pkg::*;
#(
  parameter int unsigned STD_DEPTH = uart_fifo_pkg::STD_DEPTH,
  parameter int unsigned EXT_DEPTH = uart_fifo_pkg::EXT_DEPTH,
  parameter int unsigned CNT_W     = $clog2(EXT_DEPTH + 1)
) (
  input  fcr_cfg_t         cfg_i,
  output logic [CNT_W-1:0] cap_o,
  output logic [CNT_W-1:0] level_o
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] S_CAP = CNT_W'(STD_DEPTH);
  localparam logic [CNT_W-1:0] S_L1  = CNT_W'(STD_DEPTH / 4);
  localparam logic [CNT_W-1:0] S_L2  = CNT_W'(STD_DEPTH / 2);
  localparam logic [CNT_W-1:0] S_L3  = CNT_W'(STD_DEPTH - 2);
  localparam logic [CNT_W-1:0] E_CAP = CNT_W'(EXT_DEPTH);
  localparam logic [CNT_W-1:0] E_L1  = CNT_W'(EXT_DEPTH / 4);
  localparam logic [CNT_W-1:0] E_L2  = CNT_W'(EXT_DEPTH / 2);
  localparam logic [CNT_W-1:0] E_L3  = CNT_W'(EXT_DEPTH - 8);

  always_comb begin
    cap_o   = ONE;
    level_o = ONE;
    if (cfg_i.en && cfg_i.ext) begin
      cap_o = E_CAP;
      unique case (cfg_i.trig)
        2'd0: level_o = ONE;
        2'd1: level_o = E_L1;
        2'd2: level_o = E_L2;
        default: level_o = E_L3;
      endcase
    end else if (cfg_i.en) begin
      cap_o = S_CAP;
      unique case (cfg_i.trig)
        2'd0: level_o = ONE;
        2'd1: level_o = S_L1;
        2'd2: level_o = S_L2;
        default: level_o = S_L3;
      endcase
    end
  end
endmodule

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [CNT_W-1:0]  cap_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic [DATA_W-1:0] dout_q;
  logic              full, do_pop, do_push;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                input logic [CNT_W-1:0] cap);
    logic [CNT_W-1:0] nxt;
    nxt = CNT_W'(p) + CNT_W'(1);
    return (nxt >= cap) ? '0 : PTR_W'(nxt);
  endfunction

  assign full    = (count_q >= cap_i);
  assign do_pop  = pop_i & (count_q != '0);
  assign do_push = push_i & (~full | do_pop);

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      dout_q   <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q, cap_i);
      if (do_pop) begin
        rd_ptr_q <= ptr_next(rd_ptr_q, cap_i);
        dout_q   <= mem_q[rd_ptr_q];
      end
      unique case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign data_o  = dout_q;
  assign count_o = count_q;
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DATA_W    = uart_fifo_pkg::DATA_W,
  parameter int unsigned STD_DEPTH = uart_fifo_pkg::STD_DEPTH,
  parameter int unsigned EXT_DEPTH = uart_fifo_pkg::EXT_DEPTH,
  parameter int unsigned CNT_W     = $clog2(EXT_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fcr_wr_i,
  input  logic [7:0]        fcr_wdata_i,
  output logic [7:0]        iir_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [CNT_W-1:0]  rx_count_o,
  output logic              rx_overrun_o,
  output logic              rx_irq_o,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [CNT_W-1:0]  tx_count_o
);
  fcr_cfg_t         cfg;
  logic             rx_clr, tx_clr;
  logic [CNT_W-1:0] cap, level;
  logic             ovr_q, rx_drop;
  logic             unused_rsvd;

  assign unused_rsvd = ^fcr_wdata_i[4:3];

  ufc_fcr_regs i_fcr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (fcr_wr_i),
    .en_bit_i     (fcr_wdata_i[0]),
    .rx_clr_bit_i (fcr_wdata_i[1]),
    .tx_clr_bit_i (fcr_wdata_i[2]),
    .ext_bit_i    (fcr_wdata_i[5]),
    .trig_i       (fcr_wdata_i[7:6]),
    .cfg_o        (cfg),
    .rx_clr_o     (rx_clr),
    .tx_clr_o     (tx_clr)
  );

  ufc_mode_map #(
    .STD_DEPTH (STD_DEPTH),
    .EXT_DEPTH (EXT_DEPTH),
    .CNT_W     (CNT_W)
  ) i_map (
    .cfg_i   (cfg),
    .cap_o   (cap),
    .level_o (level)
  );

  ufc_byte_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (EXT_DEPTH),
    .CNT_W  (CNT_W)
  ) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_clr),
    .cap_i   (cap),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (rx_pop_i),
    .data_o  (rx_data_o),
    .count_o (rx_count_o)
  );

  ufc_byte_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (EXT_DEPTH),
    .CNT_W  (CNT_W)
  ) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tx_clr),
    .cap_i   (cap),
    .push_i  (tx_push_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop_i),
    .data_o  (tx_data_o),
    .count_o (tx_count_o)
  );

  // full with no same-cycle pop: byte is lost
  assign rx_drop = rx_push_i & ~rx_pop_i & (rx_count_o >= cap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovr_q <= 1'b0;
    else if (rx_clr)  ovr_q <= 1'b0;
    else if (rx_drop) ovr_q <= 1'b1;
  end

  assign rx_overrun_o = ovr_q;
  assign rx_irq_o     = (rx_count_o >= level);
  assign iir_o        = {cfg.en, cfg.en, cfg.en & cfg.ext, 1'b0,
                         rx_irq_o ? 4'b0100 : 4'b0001};
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STD_DEPTH = 16,
  parameter int unsigned EXT_DEPTH = 64,
  parameter int unsigned CNT_W     = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fcr_wr_i,
  input logic [7:0]        fcr_wdata_i,
  input logic [7:0]        iir_o,
  input logic              rx_push_i,
  input logic              rx_pop_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic [CNT_W-1:0]  rx_count_o,
  input logic              rx_overrun_o,
  input logic              rx_irq_o,
  input logic [CNT_W-1:0]  tx_count_o
);
  logic [CNT_W-1:0] cap_now;
  assign cap_now = !iir_o[7] ? CNT_W'(1) : (iir_o[5] ? CNT_W'(EXT_DEPTH) : CNT_W'(STD_DEPTH));

  p_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_o <= cap_now) && (tx_count_o <= cap_now));

  p_ext_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[5] |-> (iir_o[7:6] == 2'b11));

  p_irq_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> (rx_count_o != '0));

  p_iir_id_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_o[4:0] == (rx_irq_o ? 5'b00100 : 5'b00001)));

  p_rx_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_wr_i && fcr_wdata_i[1]) |=> ((rx_count_o == '0) && !rx_overrun_o));

  p_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_wr_i && (fcr_wdata_i[0] != iir_o[7])) |=> ((rx_count_o == '0) && (tx_count_o == '0)));

  p_overrun_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_overrun_o && !fcr_wr_i) |=> rx_overrun_o);

  p_step_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fcr_wr_i |=> (32'(rx_count_o) <= 32'($past(rx_count_o)) + 32'd1));

  p_empty_pop_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && !rx_push_i && !fcr_wr_i && (rx_count_o == '0)) |=> ($stable(rx_data_o) && (rx_count_o == '0)));
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(
  .DATA_W    (DATA_W),
  .STD_DEPTH (STD_DEPTH),
  .EXT_DEPTH (EXT_DEPTH),
  .CNT_W     (CNT_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fcr_wr_i     (fcr_wr_i),
  .fcr_wdata_i  (fcr_wdata_i),
  .iir_o        (iir_o),
  .rx_push_i    (rx_push_i),
  .rx_pop_i     (rx_pop_i),
  .rx_data_o    (rx_data_o),
  .rx_count_o   (rx_count_o),
  .rx_overrun_o (rx_overrun_o),
  .rx_irq_o     (rx_irq_o),
  .tx_count_o   (tx_count_o)
);

// File: tb/test_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fcr_wr = 1'b0;
  logic [7:0] fcr_wdata = '0;
  logic [7:0] iir;
  logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_din = '0, tx_din = '0, rx_dout, tx_dout;
  logic [6:0] rx_cnt, tx_cnt;
  logic       rx_ovr, rx_irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  uart_fifo_ctrl i_uart_fifo_ctrl (
    .clk_i (clk), .rst_ni (rst_n),
    .fcr_wr_i (fcr_wr), .fcr_wdata_i (fcr_wdata), .iir_o (iir),
    .rx_push_i (rx_push), .rx_data_i (rx_din), .rx_pop_i (rx_pop),
    .rx_data_o (rx_dout), .rx_count_o (rx_cnt), .rx_overrun_o (rx_ovr), .rx_irq_o (rx_irq),
    .tx_push_i (tx_push), .tx_data_i (tx_din), .tx_pop_i (tx_pop),
    .tx_data_o (tx_dout), .tx_count_o (tx_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr_fcr(input logic [7:0] v);
    fcr_wr = 1'b1; fcr_wdata = v;
    @(negedge clk);
    fcr_wr = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] v);
    rx_push = 1'b1; rx_din = v;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] v);
    tx_push = 1'b1; tx_din = v;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] v);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    v = rx_dout;
  endtask

  task automatic pop_tx(output logic [7:0] v);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
    v = tx_dout;
  endtask

  task automatic t_reset();
    check(iir == 8'h01, "R1 iir", iir, 8'h01);
    check(rx_cnt == 0 && tx_cnt == 0, "R1 counts", rx_cnt + tx_cnt, 0);
    check(!rx_irq && !rx_ovr, "R1 irq/ovr", {rx_irq, rx_ovr}, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    push_rx(8'hA5);
    check(rx_irq == 1'b1, "R6 disabled level 1", rx_irq, 1);
    check(iir == 8'h04, "R9 iir pending", iir, 8'h04);
    push_rx(8'h5A);
    check(rx_cnt == 1, "R2 disabled holds one", rx_cnt, 1);
    check(rx_ovr == 1'b1, "R12 overrun set", rx_ovr, 1);
    pop_rx(d);
    check(d == 8'hA5, "R13 first byte kept", d, 8'hA5);
    check(rx_ovr == 1'b1, "R12 overrun sticky", rx_ovr, 1);
    check(iir == 8'h01, "R9 iir idle", iir, 8'h01);
  endtask

  task automatic t_levels(input bit ext);
    int lv[4];
    logic [7:0] d;
    lv = ext ? '{1, 16, 32, 56} : '{1, 4, 8, 14};
    for (int c = 0; c < 4; c++) begin
      wr_fcr(8'((c << 6) | (ext ? 8'h23 : 8'h03)));
      check(iir[7:5] == (ext ? 3'b111 : 3'b110), ext ? "R3 mode bits" : "R2 mode bits", iir[7:5], ext ? 7 : 6);
      for (int i = 0; i < lv[c] - 1; i++) push_rx(8'(i));
      check(rx_irq == 1'b0, ext ? "R7 below level" : "R6 below level", rx_irq, 0);
      push_rx(8'hEE);
      check(rx_irq == 1'b1, ext ? "R7 at level" : "R6 at level", rx_irq, 1);
      check(iir[3:0] == 4'b0100, "R9 pending code", iir[3:0], 4);
      pop_rx(d);
      check(rx_irq == 1'b0, "R8 falls below level", rx_irq, 0);
    end
  endtask

  task automatic t_capacity(input bit ext);
    int cap;
    logic [7:0] d;
    cap = ext ? 64 : 16;
    wr_fcr(ext ? 8'hE3 : 8'hC3);
    check(rx_ovr == 1'b0, "R10 clear drops overrun", rx_ovr, 0);
    for (int i = 0; i <= cap; i++) push_rx(8'(i + 8'h10));
    check(rx_cnt == 7'(cap), ext ? "R5 capacity" : "R4 capacity", rx_cnt, cap);
    check(rx_ovr == 1'b1, "R12 overflow flag", rx_ovr, 1);
    for (int i = 0; i < cap; i++) begin
      pop_rx(d);
      if (d != 8'(i + 8'h10)) check(1'b0, "R13 order", d, i + 8'h10);
      if (!ext && i == 2) check(rx_irq == 1'b0 && rx_cnt == 13, "R8 deassert at 13", rx_irq, 0);
    end
    check(rx_cnt == 0, "R13 drained", rx_cnt, 0);
    pop_rx(d);
    check(d == 8'(cap - 1 + 8'h10), "R13 empty pop keeps data", d, cap - 1 + 8'h10);
    check(rx_cnt == 0, "R13 empty pop count", rx_cnt, 0);
  endtask

  task automatic t_ext_needs_en();
    wr_fcr(8'h20);
    check(iir[7:5] == 3'b000, "R3 ext ignored when disabled", iir[7:5], 0);
    push_rx(8'h01); push_rx(8'h02);
    check(rx_cnt == 1, "R3 depth one when disabled", rx_cnt, 1);
  endtask

  task automatic t_clears();
    wr_fcr(8'h01);
    check(rx_cnt == 0, "R11 enable change flushes", rx_cnt, 0);
    for (int i = 0; i < 3; i++) begin push_rx(8'(i)); push_tx(8'(i)); end
    wr_fcr(8'h05);
    check(tx_cnt == 0 && rx_cnt == 3, "R10 tx clear only", tx_cnt, 0);
    push_tx(8'h77);
    wr_fcr(8'h01);
    check(rx_cnt == 3 && tx_cnt == 1, "R10 strobes not stored", rx_cnt, 3);
    wr_fcr(8'h03);
    check(rx_cnt == 0 && tx_cnt == 1, "R10 rx clear only", rx_cnt, 0);
    push_rx(8'h44);
    wr_fcr(8'h21);
    check(rx_cnt == 0 && tx_cnt == 0, "R11 ext change flushes", rx_cnt + tx_cnt, 0);
    push_rx(8'h44); push_tx(8'h55);
    wr_fcr(8'h20);
    check(rx_cnt == 0 && tx_cnt == 0, "R11 disable flushes", rx_cnt + tx_cnt, 0);
  endtask

  task automatic t_tx_order();
    logic [7:0] d;
    wr_fcr(8'h01);
    for (int i = 0; i < 5; i++) push_tx(8'(8'hC0 + i));
    check(tx_cnt == 5, "R4 tx count", tx_cnt, 5);
    for (int i = 0; i < 5; i++) begin
      pop_tx(d);
      check(d == 8'(8'hC0 + i), "R13 tx order", d, 8'hC0 + i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_levels(1'b0);
    t_capacity(1'b0);
    t_levels(1'b1);
    t_capacity(1'b1);
    t_ext_needs_en();
    t_clears();
    t_tx_order();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule